// File: doc/BRIEF.md
# Row-Column Selected Word Array

This block is a small synchronous storage array of data words. A binary address is split into a row part and a column part. Two decoders turn these parts into one-hot row lines and one-hot column lines. Every storage element is the same circuit: it is enabled only where its row line and its column line are both high, so no element compares addresses itself. All data, in both directions, moves over one shared bidirectional bus. The array drives that bus only during a read and samples it on a write.

A build parameter selects a second decode variant for comparison. In that variant the row and column decoders are absent. Each element instead receives the whole address and matches it against its own index with a wide AND of bit-equality terms. Both variants give the same storage behaviour, so a user can weigh the cost of a shared decoder against the cost of a comparator in every element.

A small access controller sorts the control pins into three named bus modes. IDLE means no access. READ means the array drives the bus. WRITE means the array captures from the bus on the clock edge. The transitions follow the pins directly, with no registered state: chip select low goes to IDLE; chip select with write enable goes to WRITE whatever read enable is; chip select with only read enable goes to READ.

Top module: `rc_word_array`

## Requirements
- R1: The upper ADDR_W-ADDR_W/2 address bits pick the row and the lower ADDR_W/2 bits pick the column. With the default ADDR_W=6 this gives an 8 by 8 grid, and each of the 64 addresses holds its own independent DATA_W-bit word (default 8).
- R2: The row select lines and the column select lines are each one-hot during an access, and no more than one line of each is high at any time.
- R3: A write stores the bus value at the addressed word on the rising clock edge when cs_i=1 and we_i=1. It changes no other word, and a word keeps its value until it is written again.
- R4: While cs_i=1, re_i=1 and we_i=0, the array drives the stored word of the current address onto data_io without waiting for a clock edge. The word follows the address as it changes.
- R5: In IDLE (cs_i=0, or both enables low) every row and column line is low and the array leaves data_io in high impedance, so a value driven by another agent reaches the bus unchanged.
- R6: With cs_i=1, we_i=1 and re_i=1 together, the write takes place and the array does not drive data_io.
- R7: A write attempt with cs_i=0 leaves the stored contents unchanged.
- R8: With DEC_MODE set to the comparator variant, each element is enabled by a full-address match against its own index. For a 4-bit address (16 words), every address reads back the same data as the one-hot variant after identical writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes are captured on its rising edge |
| cs_i | input | 1 | Chip select, active high |
| we_i | input | 1 | Write enable, active high; has priority over read |
| re_i | input | 1 | Read enable, active high |
| addr_i | input | ADDR_W | Word address; upper part is the row, lower part is the column |
| data_io | inout | DATA_W | Shared bidirectional data bus |

## Verification
The hardest case to reach from the ports is showing that the array does not drive the bus. The array has no output besides the bus itself. The stimulus therefore stores a known word at the address, asserts the controls that should leave the bus free (deselected, or read and write together), and drives two complementary patterns through the bench's own bus driver. Both patterns must arrive unchanged, which would fail if the array's stored word were also driven onto the bus. A full write-then-read sweep over every address, a second overwrite sweep, and a lockstep comparison of a 16-word one-hot array against a 16-word comparator array cover the selection paths.

// File: rtl/rcm_pkg.sv
package rcm_pkg;

    typedef enum logic {
        DEC_ONEHOT  = 1'b0,
        DEC_COMPARE = 1'b1
    } dec_mode_e;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_READ  = 2'd1,
        BUS_WRITE = 2'd2
    } bus_mode_e;

endpackage

// File: rtl/rcm_onehot_dec.sv
module rcm_onehot_dec #(
    parameter int IN_W = 3,
    localparam int OUT_N = 1 << IN_W
) (
    input  logic             en_i,
    input  logic [IN_W-1:0]  code_i,
    output logic [OUT_N-1:0] lines_o
);

    always_comb begin
        lines_o = '0;
        if (en_i) begin
            lines_o[code_i] = 1'b1;
        end
    end

    // R2: never more than one line, exactly one while enabled
    always_comb begin
        p_dec_onehot_r2: assert ($onehot0(lines_o));
        if (en_i) begin
            p_dec_active_r2: assert ($countones(lines_o) == 1);
        end
    end

endmodule

// File: rtl/rcm_bus_ctrl.sv
module rcm_bus_ctrl
    import rcm_pkg::*;
(
    input  logic      cs_i,
    input  logic      we_i,
    input  logic      re_i,
    output bus_mode_e mode_o,
    output logic      access_o,
    output logic      write_o,
    output logic      drive_o
);

    always_comb begin
        unique case ({cs_i, we_i, re_i})
            3'b110, 3'b111: mode_o = BUS_WRITE;
            3'b101:         mode_o = BUS_READ;
            default:        mode_o = BUS_IDLE;
        endcase
    end

    always_comb begin
        access_o = 1'b0;
        write_o  = 1'b0;
        drive_o  = 1'b0;
        unique case (mode_o)
            BUS_WRITE: begin
                access_o = 1'b1;
                write_o  = 1'b1;
            end
            BUS_READ: begin
                access_o = 1'b1;
                drive_o  = 1'b1;
            end
            default: ;
        endcase
    end

    // R6: a write request must never turn the bus driver on
    always_comb begin
        if (we_i) begin
            p_no_drive_on_write_r6: assert (!drive_o);
        end
        if (!cs_i) begin
            p_deselect_idle_r5: assert (!access_o && !drive_o);
        end
    end

endmodule

// File: rtl/rcm_word_cell.sv
module rcm_word_cell #(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              line_a_i,
    input  logic              line_b_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic              sel;
    logic [DATA_W-1:0] word_q;

    assign sel = line_a_i & line_b_i;

    always_ff @(posedge clk_i) begin
        if (sel && wr_i) begin
            word_q <= wdata_i;
        end
    end

    // gated, non-inverting read path; zero when not selected for a read
    assign rdata_o = (sel && rd_i) ? word_q : '0;

endmodule

// File: rtl/rc_word_array.sv
module rc_word_array
    import rcm_pkg::*;
#(
    parameter int        ADDR_W   = 6,
    parameter int        DATA_W   = 8,
    parameter dec_mode_e DEC_MODE = DEC_ONEHOT
) (
    input  logic              clk_i,
    input  logic              cs_i,
    input  logic              we_i,
    input  logic              re_i,
    input  logic [ADDR_W-1:0] addr_i,
    inout  wire  [DATA_W-1:0] data_io
);

    localparam int COL_W = ADDR_W / 2;
    localparam int ROW_W = ADDR_W - COL_W;
    localparam int ROWS  = 1 << ROW_W;
    localparam int COLS  = 1 << COL_W;
    localparam int DEPTH = ROWS * COLS;

    bus_mode_e         mode;
    logic              access;
    logic              write;
    logic              drive;
    logic [ROWS-1:0]   row_sel;
    logic [COLS-1:0]   col_sel;
    logic [DEPTH-1:0]  cell_en;
    logic [DATA_W-1:0] cell_rd [DEPTH];
    logic [DATA_W-1:0] rd_bus;

    rcm_bus_ctrl u_ctrl (
        .cs_i     (cs_i),
        .we_i     (we_i),
        .re_i     (re_i),
        .mode_o   (mode),
        .access_o (access),
        .write_o  (write),
        .drive_o  (drive)
    );

    generate
        if (DEC_MODE == DEC_ONEHOT) begin : g_shared_dec
            rcm_onehot_dec #(.IN_W(ROW_W)) u_row_dec (
                .en_i    (access),
                .code_i  (addr_i[ADDR_W-1:COL_W]),
                .lines_o (row_sel)
            );
            rcm_onehot_dec #(.IN_W(COL_W)) u_col_dec (
                .en_i    (access),
                .code_i  (addr_i[COL_W-1:0]),
                .lines_o (col_sel)
            );
        end else begin : g_no_dec
            assign row_sel = '0;
            assign col_sel = '0;
        end
    endgenerate

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_cell
            localparam logic [ADDR_W-1:0] IDX = ADDR_W'(gi);
            logic line_a;
            logic line_b;
            if (DEC_MODE == DEC_ONEHOT) begin : g_grid
                assign line_a = row_sel[gi / COLS];
                assign line_b = col_sel[gi % COLS];
            end else begin : g_match
                assign line_a = access;
                assign line_b = &(~(addr_i ^ IDX));
            end
            assign cell_en[gi] = line_a & line_b;
            rcm_word_cell #(.DATA_W(DATA_W)) u_cell (
                .clk_i    (clk_i),
                .line_a_i (line_a),
                .line_b_i (line_b),
                .wr_i     (write),
                .rd_i     (drive),
                .wdata_i  (data_io),
                .rdata_o  (cell_rd[gi])
            );
        end
    endgenerate

    always_comb begin
        rd_bus = '0;
        for (int i = 0; i < DEPTH; i++) begin
            rd_bus = rd_bus | cell_rd[i];
        end
    end

    assign data_io = drive ? rd_bus : {DATA_W{1'bz}};

    // R2, R3, R5: selection stays single and is cleared outside accesses
    always_comb begin
        p_one_cell_r3: assert ($countones(cell_en) <= 1);
        p_rows_onehot_r2: assert ($onehot0(row_sel) && $onehot0(col_sel));
        if (mode == BUS_IDLE) begin
            p_idle_lines_low_r5: assert (row_sel == '0 && col_sel == '0 && cell_en == '0);
        end else begin
            p_access_one_cell_r1: assert ($countones(cell_en) == 1);
        end
    end

endmodule

// File: tb/rc_word_array_tb.sv
module rc_word_array_tb;
    import rcm_pkg::*;

    logic       clk = 1'b0;
    logic       cs = 1'b0;
    logic       we = 1'b0;
    logic       re = 1'b0;
    logic [5:0] addr = '0;
    logic       tb_drv = 1'b0;
    logic [7:0] tb_val = '0;
    wire  [7:0] bus6;
    wire  [7:0] bus_oh;
    wire  [7:0] bus_cmp;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign bus6    = tb_drv ? tb_val : 8'bz;
    assign bus_oh  = tb_drv ? tb_val : 8'bz;
    assign bus_cmp = tb_drv ? tb_val : 8'bz;

    rc_word_array #(.ADDR_W(6), .DATA_W(8), .DEC_MODE(DEC_ONEHOT)) u_dut (
        .clk_i(clk), .cs_i(cs), .we_i(we), .re_i(re), .addr_i(addr), .data_io(bus6)
    );
    rc_word_array #(.ADDR_W(4), .DATA_W(8), .DEC_MODE(DEC_ONEHOT)) u_oh4 (
        .clk_i(clk), .cs_i(cs), .we_i(we), .re_i(re), .addr_i(addr[3:0]), .data_io(bus_oh)
    );
    rc_word_array #(.ADDR_W(4), .DATA_W(8), .DEC_MODE(DEC_COMPARE)) u_cmp4 (
        .clk_i(clk), .cs_i(cs), .we_i(we), .re_i(re), .addr_i(addr[3:0]), .data_io(bus_cmp)
    );

    function automatic logic [7:0] pat(input int a, input int pass);
        return 8'((a * 37 + 11 + pass * 100) & 8'hFF);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_write(input int a, input logic [7:0] v, input logic c, input logic r);
        @(negedge clk);
        addr = 6'(a); tb_val = v; tb_drv = 1'b1; cs = c; we = 1'b1; re = r;
        @(negedge clk);
        cs = 1'b0; we = 1'b0; re = 1'b0; tb_drv = 1'b0;
    endtask

    task automatic start_read(input int a);
        @(negedge clk);
        tb_drv = 1'b0; addr = 6'(a); cs = 1'b1; we = 1'b0; re = 1'b1;
        #1;
    endtask

    task automatic end_read();
        cs = 1'b0; re = 1'b0;
    endtask

    initial begin
        // Watchdog
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // Start state, R5: bus free while deselected, bench value passes through
        @(negedge clk);
        tb_drv = 1'b1; tb_val = 8'h3C; #1;
        check("R5 start bus free", bus6, 8'h3C);
        tb_drv = 1'b0;

        // R1/R3: fill every address, then read each back
        for (int a = 0; a < 64; a++) do_write(a, pat(a, 0), 1'b1, 1'b0);
        for (int a = 0; a < 64; a++) begin
            start_read(a);
            check("R1 R4 sweep read", bus6, pat(a, 0));
            end_read();
        end

        // R3: overwrite only odd addresses, evens keep old data
        for (int a = 1; a < 64; a += 2) do_write(a, pat(a, 1), 1'b1, 1'b0);
        for (int a = 0; a < 64; a++) begin
            start_read(a);
            check("R3 overwrite keep", bus6, (a % 2 == 1) ? pat(a, 1) : pat(a, 0));
            end_read();
        end

        // R4: read follows address change with no clock edge
        @(negedge clk);
        tb_drv = 1'b0; cs = 1'b1; re = 1'b1; addr = 6'd9; #0.5;
        check("R4 comb read a", bus6, pat(9, 1));
        addr = 6'd20; #0.5;
        check("R4 comb read b", bus6, pat(20, 0));
        end_read();

        // R7: write with chip deselected has no effect
        do_write(20, 8'h00, 1'b0, 1'b0);
        start_read(20);
        check("R7 deselected write ignored", bus6, pat(20, 0));
        end_read();

        // R5: idle with address on a stored word, two patterns pass through
        @(negedge clk);
        addr = 6'd20; cs = 1'b1; we = 1'b0; re = 1'b0; tb_drv = 1'b1;
        tb_val = 8'h55; #1;
        check("R5 idle high-z p1", bus6, 8'h55);
        tb_val = 8'hAA; #1;
        check("R5 idle high-z p2", bus6, 8'hAA);
        cs = 1'b0; re = 1'b1; tb_val = 8'h0F; #1;
        check("R5 deselect read high-z", bus6, 8'h0F);
        re = 1'b0; tb_drv = 1'b0;

        // R6: read and write together, write wins and array does not drive
        @(negedge clk);
        addr = 6'd33; tb_drv = 1'b1; cs = 1'b1; we = 1'b1; re = 1'b1;
        tb_val = 8'hC3; #1;
        check("R6 no drive p1", bus6, 8'hC3);
        tb_val = 8'h3C; #1;
        check("R6 no drive p2", bus6, 8'h3C);
        @(negedge clk);
        cs = 1'b0; we = 1'b0; re = 1'b0; tb_drv = 1'b0;
        start_read(33);
        check("R6 write taken", bus6, 8'h3C);
        end_read();

        // R8: one-hot and comparator 16-word arrays agree on every address
        for (int a = 0; a < 16; a++) do_write(a, pat(a, 2), 1'b1, 1'b0);
        for (int a = 0; a < 16; a++) begin
            start_read(a);
            check("R8 compare vs onehot", bus_cmp, bus_oh);
            check("R8 compare value", bus_cmp, pat(a, 2));
            end_read();
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule